// File: doc/BRIEF.md
# Input Capture Unit with Prescaler

The unit records a 16-bit timestamp whenever a qualifying edge shows up on an asynchronous capture pin. A 4-bit mode field decides what counts as an event: each falling edge, each rising edge, each 4th rising edge, or each 16th rising edge. A one-bit source select picks which of two free-running timer values is stored. Each capture raises a sticky request flag. The flag stays high until software pulses a clear strobe.

The pin passes through a synchronizer, and edges are found by comparing successive synchronized samples. A prescaler counts rising edges for the divided modes. The prescaler count is reset only while the unit is off or in a non-capture code. Changing the ratio between capture modes leaves the count alone, so the first capture after such a change can come early. If the mode changes between two capture codes while an edge is being detected, the flag is raised once without a new timestamp.

Top module: `icap_unit`

## Requirements
- R1: Mode code 4'b0100 captures on every falling edge of the pin and never on a rising edge.
- R2: Mode code 4'b0101 captures on every rising edge of the pin and never on a falling edge.
- R3: Mode code 4'b0110 captures on every 4th rising edge and 4'b0111 on every 16th rising edge, with the count starting from zero after the unit has been off.
- R4: With `src_sel` = 0 the stored value is `tmr_a`, and with `src_sel` = 1 it is `tmr_b`.
- R5: A pin change first sampled at clock edge k updates `cap_value` and `cap_flag` at clock edge k+2, and the stored value is the timer value present at edge k+2.
- R6: `cap_flag` stays high until a cycle in which `flag_clr` is high, and then it falls.
- R7: When a capture and `flag_clr` occur in the same cycle, `cap_flag` ends up high.
- R8: A second capture before the flag is cleared overwrites `cap_value` with the newer timestamp.
- R9: Code 4'b0000 (off) and every code outside 4'b0100 to 4'b0111 give no capture and hold the prescaler count at zero.
- R10: Switching between the divided and undivided capture codes keeps the prescaler count. After 6 rising edges in ÷16, a switch to ÷4 captures on the very next rising edge.
- R11: A change of `mode` between two capture codes, in the same cycle as a detected edge that is not itself a capture, sets `cap_flag` and leaves `cap_value` unchanged.
- R12: After reset, `cap_value` is 0 and `cap_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_pin | input | 1 | Asynchronous capture pin |
| tmr_a | input | 16 | Timer value, source 0 |
| tmr_b | input | 16 | Timer value, source 1 |
| mode | input | 4 | Event mode code |
| src_sel | input | 1 | Timestamp source select |
| flag_clr | input | 1 | Flag clear strobe |
| cap_value | output | 16 | Captured timestamp |
| cap_flag | output | 1 | Sticky capture request flag |

## Verification
The hardest case to reach from the ports is the spurious flag. It needs a mode change to land in the single cycle in which the edge detector is asserted, two clocks after the pin moves. The stimulus drives a falling edge while the unit is in a rising-only divided mode. It then counts clock edges and changes the mode on the negative edge just before the detection cycle ends.

The early first capture after a ratio change is reached in a similar way. The bench leaves a known count of rising edges in ÷16 and then switches to ÷4 without passing through off.

// File: rtl/icap_pkg.sv
package icap_pkg;
    localparam logic [3:0] MODE_OFF   = 4'b0000;
    localparam logic [3:0] MODE_FALL  = 4'b0100;
    localparam logic [3:0] MODE_RISE  = 4'b0101;
    localparam logic [3:0] MODE_DIV_L = 4'b0110;
    localparam logic [3:0] MODE_DIV_H = 4'b0111;

    function automatic logic is_capture(input logic [3:0] m);
        return (m[3:2] == 2'b01);
    endfunction
endpackage

// File: rtl/icap_sync_edge.sv
module icap_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], pin};
        st_d.prev = st_q.sh[STAGES-1];
        rise      = st_q.sh[STAGES-1] & ~st_q.prev;
        fall      = ~st_q.sh[STAGES-1] & st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    // R5
    fall_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/icap_prescaler.sv
module icap_prescaler
    import icap_pkg::*;
#(
    parameter int DIV_LO = 4,
    parameter int DIV_HI = 16,
    parameter int CNT_W  = $clog2(DIV_HI + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] mode,
    input  logic       rise,
    input  logic       fall,
    output logic       fire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_st_t;

    pre_st_t          st_d, st_q;
    logic [CNT_W-1:0] ratio;
    logic [CNT_W-1:0] step;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        step = st_q.cnt + CNT_W'(1);
        unique case (mode)
            MODE_DIV_L: ratio = CNT_W'(DIV_LO);
            MODE_DIV_H: ratio = CNT_W'(DIV_HI);
            default:    ratio = CNT_W'(1);
        endcase
        if (!is_capture(mode)) begin
            st_d.cnt = '0;
        end else if (mode == MODE_FALL) begin
            fire = fall;
        end else if (rise) begin
            if (step >= ratio) begin
                fire     = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = step;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9
    cnt_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_capture(mode) |=> (st_q.cnt == '0));
    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CNT_W'(DIV_HI));
endmodule

// File: rtl/icap_unit.sv
module icap_unit
    import icap_pkg::*;
#(
    parameter int TS_W        = 16,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_LO      = 4,
    parameter int DIV_HI      = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_pin,
    input  logic [TS_W-1:0] tmr_a,
    input  logic [TS_W-1:0] tmr_b,
    input  logic [3:0]      mode,
    input  logic            src_sel,
    input  logic            flag_clr,
    output logic [TS_W-1:0] cap_value,
    output logic            cap_flag
);
    localparam int CNT_W = $clog2(DIV_HI + 1);

    typedef struct packed {
        logic [TS_W-1:0] value;
        logic            flag;
        logic [3:0]      mode_prev;
    } unit_st_t;

    unit_st_t st_d, st_q;
    logic     rise, fall, fire, spurious, set_flag;

    icap_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (cap_pin),
        .rise (rise),
        .fall (fall)
    );

    icap_prescaler #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI), .CNT_W(CNT_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .mode (mode),
        .rise (rise),
        .fall (fall),
        .fire (fire)
    );

    always_comb begin
        st_d           = st_q;
        st_d.mode_prev = mode;
        spurious = is_capture(mode) && is_capture(st_q.mode_prev)
                   && (mode != st_q.mode_prev) && (rise || fall);
        set_flag = fire || spurious;
        if (fire) st_d.value = src_sel ? tmr_b : tmr_a;
        if (set_flag)      st_d.flag = 1'b1;
        else if (flag_clr) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_value = st_q.value;
    assign cap_flag  = st_q.flag;

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag && !flag_clr) |=> cap_flag);
    // R8
    value_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_value) |-> cap_flag);
    // R9
    off_holds_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_capture(mode) |=> $stable(cap_value));
    // R7
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && flag_clr) |=> cap_flag);
endmodule

// File: tb/icap_unit_bench.sv
module icap_unit_bench;
    import icap_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_pin = 1'b0;
    logic [15:0] tmr_a = '0, tmr_b = '0;
    logic [3:0]  mode = MODE_OFF;
    logic        src_sel = 1'b0;
    logic        flag_clr = 1'b0;
    logic [15:0] cap_value;
    logic        cap_flag;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_val = '0;

    always #10 clk = ~clk;

    icap_unit u_icap_unit (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin),
        .tmr_a(tmr_a), .tmr_b(tmr_b), .mode(mode), .src_sel(src_sel),
        .flag_clr(flag_clr), .cap_value(cap_value), .cap_flag(cap_flag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // moves the pin and returns at the negedge after the capture edge
    task automatic drive_pin(input logic v, input logic [15:0] ta, input logic [15:0] tb);
        @(negedge clk);
        cap_pin = v; tmr_a = ta; tmr_b = tb;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic set_mode(input logic [3:0] m);
        @(negedge clk);
        mode = m;
        @(negedge clk);
    endtask

    task automatic expect_cap(input string req, input logic hit, input logic [15:0] ta, input logic [15:0] tb);
        if (hit) exp_val = src_sel ? tb : ta;
        check(req, {31'b0, cap_flag}, {31'b0, hit});
        check(req, {16'b0, cap_value}, {16'b0, exp_val});
        if (cap_flag) clear_flag();
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] ta, tb;
        repeat (4) @(negedge clk);
        // R12 reset state
        check("R12", {16'b0, cap_value}, 32'h0);
        check("R12", {31'b0, cap_flag}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4: sweep of all four event modes with alternating source
        for (int m = 0; m < 4; m++) begin
            logic [3:0] code;
            int ratio;
            string req;
            code  = 4'b0100 | 4'(m);
            ratio = (m == 2) ? 4 : (m == 3) ? 16 : 1;
            req   = (m == 0) ? "R1" : (m == 1) ? "R2" : "R3";
            set_mode(MODE_OFF);
            src_sel = m[0];
            set_mode(code);
            for (int i = 1; i <= 20; i++) begin
                ta = 16'(i * 37 + m * 1000);
                tb = ta ^ 16'h5A5A;
                drive_pin(1'b1, ta, tb);
                expect_cap(req, (m != 0) && (i % ratio == 0), ta, tb);
                drive_pin(1'b0, ta + 16'd1, tb + 16'd1);
                expect_cap(req, m == 0, ta + 16'd1, tb + 16'd1);
            end
        end

        // R4 explicit source choice
        set_mode(MODE_RISE);
        src_sel = 1'b1;
        drive_pin(1'b1, 16'h1111, 16'h2222);
        check("R4", {16'b0, cap_value}, 32'h2222);
        clear_flag();
        drive_pin(1'b0, 16'h0, 16'h0);
        src_sel = 1'b0;
        drive_pin(1'b1, 16'h3333, 16'h4444);
        check("R4", {16'b0, cap_value}, 32'h3333);
        clear_flag();
        drive_pin(1'b0, 16'h0, 16'h0);

        // R5 exact capture cycle and timer sample point
        @(negedge clk);
        cap_pin = 1'b1; tmr_a = 16'hAAAA;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check("R5", {31'b0, cap_flag}, 32'h0);
        check("R5", {16'b0, cap_value}, 32'h3333);
        tmr_a = 16'hBBBB;
        @(posedge clk); @(negedge clk);
        check("R5", {31'b0, cap_flag}, 32'h1);
        check("R5", {16'b0, cap_value}, 32'hBBBB);

        // R6 flag sticks, then clears
        repeat (5) @(negedge clk);
        check("R6", {31'b0, cap_flag}, 32'h1);
        clear_flag();
        check("R6", {31'b0, cap_flag}, 32'h0);
        drive_pin(1'b0, 16'h0, 16'h0);

        // R8 overwrite without clearing
        drive_pin(1'b1, 16'h0101, 16'h0);
        drive_pin(1'b0, 16'h0, 16'h0);
        drive_pin(1'b1, 16'h0202, 16'h0);
        check("R8", {16'b0, cap_value}, 32'h0202);
        check("R8", {31'b0, cap_flag}, 32'h1);
        clear_flag();
        drive_pin(1'b0, 16'h0, 16'h0);

        // R7 set and clear together
        flag_clr = 1'b1;
        drive_pin(1'b1, 16'h0707, 16'h0);
        check("R7", {31'b0, cap_flag}, 32'h1);
        check("R7", {16'b0, cap_value}, 32'h0707);
        flag_clr = 1'b0;
        clear_flag();
        drive_pin(1'b0, 16'h0, 16'h0);
        exp_val = 16'h0707;

        // R9 non-capture code clears the count and blocks captures
        set_mode(MODE_OFF);
        set_mode(MODE_DIV_L);
        for (int i = 0; i < 2; i++) begin
            drive_pin(1'b1, 16'h0900, 16'h0);
            drive_pin(1'b0, 16'h0, 16'h0);
        end
        set_mode(4'b0011);
        drive_pin(1'b1, 16'h0911, 16'h0);
        expect_cap("R9", 1'b0, 16'h0911, 16'h0);
        drive_pin(1'b0, 16'h0, 16'h0);
        set_mode(MODE_DIV_L);
        for (int i = 1; i <= 4; i++) begin
            drive_pin(1'b1, 16'(16'h0920 + i), 16'h0);
            expect_cap("R9", i == 4, 16'(16'h0920 + i), 16'h0);
            drive_pin(1'b0, 16'h0, 16'h0);
        end

        // R10 ratio change keeps the count: early capture
        set_mode(MODE_OFF);
        set_mode(MODE_DIV_H);
        for (int i = 0; i < 6; i++) begin
            drive_pin(1'b1, 16'h0A00, 16'h0);
            drive_pin(1'b0, 16'h0, 16'h0);
        end
        check("R10", {31'b0, cap_flag}, 32'h0);
        set_mode(MODE_DIV_L);
        drive_pin(1'b1, 16'h0A55, 16'h0);
        expect_cap("R10", 1'b1, 16'h0A55, 16'h0);

        // R11 mode change in the detection cycle of a non-capturing edge
        @(negedge clk);
        cap_pin = 1'b0; tmr_a = 16'hDEAD;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        mode = MODE_DIV_H;
        @(posedge clk); @(negedge clk);
        check("R11", {31'b0, cap_flag}, 32'h1);
        check("R11", {16'b0, cap_value}, {16'b0, exp_val});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule